// File: doc/BRIEF.md
# ADC Sample FIFO with Status

This block collects conversion results from an analog-to-digital front end into an on-chip FIFO and reports occupancy and event status to a host register port. Every conversion strobe (a single-cycle pulse) packs the 12-bit result and three marker lines into one 16-bit word. The host drains the FIFO with read pulses.

The host sees three active-high occupancy flags, a sticky overrun bit and a counter interrupt. The counter fires once every N stored samples. A full FIFO refuses further conversions. In stop mode, the counter expiry also halts acquisition until the host reloads the counter or clears the FIFO. Separate command pulses empty the FIFO and clear the overrun bit.

Top module: `adc_sample_fifo`

## Requirements
- R1: A stored word is {sample[11:0] in bits 15..4, a zero in bit 3, markers[2:0] in bits 2..0}.
- R2: flag_not_empty is 1 when at least one word is held. flag_half_empty is 1 while fewer than DEPTH/2 words are held. flag_not_full is 0 exactly when DEPTH words are held.
- R3: The flags and the overrun bit are registered. They reflect a push, pop or clear on the first cycle after it.
- R4: A conversion strobe that arrives while the FIFO is full stores nothing and leaves the FIFO contents unchanged.
- R5: A strobe that arrives while the FIFO is full sets overrun. Overrun stays set until an ovr_clear pulse.
- R6: A fifo_clear pulse empties the FIFO on the next cycle: not-empty goes to 0, half-empty to 1 and not-full to 1.
- R7: A read pulse while the FIFO is empty leaves rd_data at its last value and moves no pointer.
- R8: cnt_load with value N-1 makes cnt_irq pulse high for one cycle on the cycle after each Nth accepted sample, and the counter then reloads.
- R9: With cnt_stop_en set, the counter expiry also halts acquisition. Later strobes are not stored until the next cnt_load or fifo_clear.
- R10: After reset the FIFO is empty, rd_data is 0, overrun, cnt_irq and acq_halted are 0, and half-empty and not-full are 1.
- R11: Words are read out in the order they were stored. rd_data is valid on the cycle after the read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_strobe | input | 1 | One-cycle pulse: a conversion result is ready |
| conv_sample | input | 12 | Conversion result |
| marker_in | input | 3 | Marker lines captured with the sample |
| rd_en | input | 1 | Host read pulse |
| rd_data | output | 16 | Word most recently read |
| fifo_clear | input | 1 | Command: empty the FIFO |
| ovr_clear | input | 1 | Command: clear the overrun bit |
| cnt_load | input | 1 | Load the sample counter from cnt_value |
| cnt_value | input | 16 | Counter reload value, N-1 |
| cnt_stop_en | input | 1 | Halt acquisition when the counter expires |
| flag_not_empty | output | 1 | FIFO holds at least one word |
| flag_half_empty | output | 1 | FIFO holds fewer than DEPTH/2 words |
| flag_not_full | output | 1 | FIFO has room |
| overrun | output | 1 | Sticky: a strobe arrived while the FIFO was full |
| cnt_irq | output | 1 | One-cycle interrupt request every N samples |
| acq_halted | output | 1 | Acquisition stopped by counter expiry |

## Verification
The assertions assume the following about the inputs:
- Each command is a single-cycle pulse.
- cnt_load and fifo_clear never fall in the same cycle as a conversion strobe.
- ovr_clear is never issued together with a strobe into a full FIFO.

Under these assumptions the counter and overrun outcomes are unambiguous. The bench drives every pulse for exactly one cycle from the falling edge and keeps all command pulses apart from strobes.

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 12,
  parameter int MARK_W   = 3,
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_strobe,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic [MARK_W-1:0] marker_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  input  logic              fifo_clear,
  input  logic              ovr_clear,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_stop_en,
  output logic              flag_not_empty,
  output logic              flag_half_empty,
  output logic              flag_not_full,
  output logic              overrun,
  output logic              cnt_irq,
  output logic              acq_halted
);
  localparam int AW   = $clog2(DEPTH);
  localparam int OW   = AW + 1;
  localparam int PAD  = WORD_W - SAMPLE_W - MARK_W;
  localparam logic [OW-1:0] FULL_N = OW'(DEPTH);
  localparam logic [OW-1:0] HALF_N = OW'(DEPTH / 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [OW-1:0]     occ, occ_nx;
  logic [CNT_W-1:0]  cnt, reload;
  logic              full, accept, pop;
  logic [WORD_W-1:0] word_in;

  assign word_in = {conv_sample, {PAD{1'b0}}, marker_in};
  assign full    = (occ == FULL_N);
  assign accept  = conv_strobe && !full && !acq_halted && !fifo_clear && !cnt_load;
  assign pop     = rd_en && (occ != '0) && !fifo_clear;

  always_comb begin
    occ_nx = occ;
    if (fifo_clear)         occ_nx = '0;
    else if (accept && !pop) occ_nx = occ + 1'b1;
    else if (pop && !accept) occ_nx = occ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= word_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      rd_data <= '0;
      flag_not_empty  <= 1'b0;
      flag_half_empty <= 1'b1;
      flag_not_full   <= 1'b1;
    end else begin
      occ <= occ_nx;
      flag_not_empty  <= (occ_nx != '0);
      flag_half_empty <= (occ_nx < HALF_N);
      flag_not_full   <= (occ_nx != FULL_N);
      if (fifo_clear) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (accept) wptr <= wptr + 1'b1;
        if (pop) begin
          rd_data <= mem[rptr];
          rptr <= rptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      overrun <= 1'b0;
    else if (conv_strobe && full && !fifo_clear)
      overrun <= 1'b1;
    else if (ovr_clear)
      overrun <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '1;
      reload     <= '1;
      cnt_irq    <= 1'b0;
      acq_halted <= 1'b0;
    end else begin
      cnt_irq <= 1'b0;
      if (cnt_load) begin
        reload     <= cnt_value;
        cnt        <= cnt_value;
        acq_halted <= 1'b0;
      end else if (fifo_clear) begin
        cnt        <= reload;
        acq_halted <= 1'b0;
      end else if (accept) begin
        if (cnt == '0) begin
          cnt_irq <= 1'b1;
          cnt     <= reload;
          if (cnt_stop_en) acq_halted <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_strobe,
  input logic              rd_en,
  input logic              fifo_clear,
  input logic              ovr_clear,
  input logic              cnt_load,
  input logic [WORD_W-1:0] rd_data,
  input logic              flag_not_empty,
  input logic              flag_half_empty,
  input logic              flag_not_full,
  input logic              overrun,
  input logic              cnt_irq,
  input logic              acq_halted
);
  p_full_sets_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_not_full && conv_strobe && !fifo_clear) |=> overrun);

  p_overrun_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !conv_strobe) |=> !overrun);

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (!flag_not_empty && flag_half_empty && flag_not_full));

  p_empty_read_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_not_empty && rd_en && !fifo_clear) |=> $stable(rd_data));

  p_irq_follows_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_irq |-> $past(conv_strobe));

  p_irq_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_irq |=> !cnt_irq || $past(conv_strobe));

  p_flag_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_not_empty |-> flag_half_empty) and (!flag_not_full |-> (flag_not_empty && !flag_half_empty)));

  p_halt_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load || fifo_clear) |=> !acq_halted);
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .rd_en(rd_en),
  .fifo_clear(fifo_clear), .ovr_clear(ovr_clear), .cnt_load(cnt_load),
  .rd_data(rd_data), .flag_not_empty(flag_not_empty),
  .flag_half_empty(flag_half_empty), .flag_not_full(flag_not_full),
  .overrun(overrun), .cnt_irq(cnt_irq), .acq_halted(acq_halted)
);

// File: tb/adc_sample_fifo_test.sv
module adc_sample_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_strobe = 1'b0, rd_en = 1'b0, fifo_clear = 1'b0, ovr_clear = 1'b0;
  logic cnt_load = 1'b0, cnt_stop_en = 1'b0;
  logic [11:0] conv_sample = '0;
  logic [2:0]  marker_in = '0;
  logic [15:0] cnt_value = '0;
  logic [15:0] rd_data;
  logic flag_not_empty, flag_half_empty, flag_not_full, overrun, cnt_irq, acq_halted;
  int checks = 0, errors = 0;
  logic [15:0] last;

  always #2 clk = ~clk;

  adc_sample_fifo uut (
    .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .conv_sample(conv_sample),
    .marker_in(marker_in), .rd_en(rd_en), .rd_data(rd_data), .fifo_clear(fifo_clear),
    .ovr_clear(ovr_clear), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .cnt_stop_en(cnt_stop_en), .flag_not_empty(flag_not_empty),
    .flag_half_empty(flag_half_empty), .flag_not_full(flag_not_full),
    .overrun(overrun), .cnt_irq(cnt_irq), .acq_halted(acq_halted)
  );

  localparam logic [30:0] VEC [6] = '{
    {12'hABC, 3'd5, 16'hABC5}, {12'hFFF, 3'd7, 16'hFFF7}, {12'h000, 3'd0, 16'h0000},
    {12'h123, 3'd2, 16'h1232}, {12'h800, 3'd1, 16'h8001}, {12'h7FF, 3'd6, 16'h7FF6}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] s, input logic [2:0] m);
    conv_sample = s; marker_in = m; conv_strobe = 1'b1;
    @(negedge clk); conv_strobe = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_clear();
    fifo_clear = 1'b1; @(negedge clk); fifo_clear = 1'b0;
  endtask

  task automatic load(input logic [15:0] v, input logic stop);
    cnt_value = v; cnt_stop_en = stop; cnt_load = 1'b1;
    @(negedge clk); cnt_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 not_empty", flag_not_empty, 0);
    check("R10 half_empty", flag_half_empty, 1);
    check("R10 not_full", flag_not_full, 1);
    check("R10 overrun", overrun, 0);
    check("R10 irq", cnt_irq, 0);
    check("R10 halted", acq_halted, 0);
    check("R10 rd_data", rd_data, 0);

    for (int i = 0; i < 6; i++) begin
      push(VEC[i][30:19], VEC[i][18:16]);
      if (i == 0) check("R3 not_empty after push", flag_not_empty, 1);
    end
    for (int i = 0; i < 6; i++) begin
      pop();
      check("R1 R11 word", rd_data, VEC[i][15:0]);
    end
    check("R3 empty after drain", flag_not_empty, 0);
    pop();
    check("R7 empty read holds", rd_data, 16'h7FF6);
    check("R7 still empty", flag_not_empty, 0);

    load(16'd2, 1'b0);
    for (int i = 0; i < 7; i++) begin
      push(12'(i), 3'd0);
      check("R8 irq every third", cnt_irq, (i == 2 || i == 5) ? 1 : 0);
    end
    pulse_clear();
    check("R6 cleared", flag_not_empty, 0);

    load(16'd1, 1'b1);
    for (int i = 1; i <= 4; i++) begin
      push(12'(i), 3'd0);
      if (i == 2) check("R9 irq at expiry", cnt_irq, 1);
    end
    check("R9 halted", acq_halted, 1);
    pop(); check("R9 first", rd_data, 16'h0010);
    pop(); check("R9 second", rd_data, 16'h0020);
    pop(); check("R9 nothing after halt", rd_data, 16'h0020);
    check("R9 empty", flag_not_empty, 0);
    load(16'hFFFF, 1'b0);
    check("R9 released", acq_halted, 0);
    push(12'h009, 3'd1);
    pop(); check("R9 stores after load", rd_data, 16'h0091);

    for (int i = 0; i < 1024; i++) begin
      push(12'(i), 3'(i));
      if (i == 510) check("R2 half_empty at 511", flag_half_empty, 1);
      if (i == 511) check("R2 half_empty at 512", flag_half_empty, 0);
      if (i == 1022) check("R2 not_full at 1023", flag_not_full, 1);
      if (i == 1023) check("R2 not_full at 1024", flag_not_full, 0);
    end
    check("R5 no overrun yet", overrun, 0);
    push(12'hEEE, 3'd3);
    check("R5 overrun set", overrun, 1);
    check("R4 still full", flag_not_full, 0);
    for (int i = 0; i < 1024; i++) begin
      pop();
      if (i == 0) check("R4 first word", rd_data, 16'h0000);
    end
    check("R4 last word", rd_data, 16'h3FF7);
    check("R4 empty after 1024 reads", flag_not_empty, 0);
    check("R5 sticky", overrun, 1);
    ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0;
    check("R5 overrun cleared", overrun, 0);

    push(12'h111, 3'd1);
    push(12'h222, 3'd2);
    last = rd_data;
    pulse_clear();
    check("R6 not_empty", flag_not_empty, 0);
    check("R6 half_empty", flag_half_empty, 1);
    check("R6 not_full", flag_not_full, 1);
    pop();
    check("R6 R7 no data after clear", rd_data, last);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule